// File: doc/BRIEF.md
# Peripheral Bus-Master Single-Word Transfer Sequencer

This block lets the custom logic of a bus peripheral move one word to or from an address outside its own space. The word never travels on a direct data path. It is staged in one of two local registers that the bus interface reaches through the peripheral's slave port. The custom logic pulses a write strobe or a read strobe together with the external address. The sequencer then issues a single request to the interface naming a source and a destination address. It waits for the interface to touch the matching staging register and then for the chained completion acknowledge. Each step is reported back to the custom logic.

The block has four states. `ST_IDLE` accepts a strobe and moves to `ST_REQ`. `ST_REQ` drives the request for exactly one cycle and moves to `ST_WAIT_SLV`, or to `ST_IDLE` on timeout. `ST_WAIT_SLV` waits for the interface's slave access to the staging register and then moves to `ST_WAIT_CMPL`, or to `ST_IDLE` on timeout. `ST_WAIT_CMPL` moves to `ST_IDLE` on the completion acknowledge, signalling done, or on timeout, signalling error. The state is held in a register and the outputs come from combinational decode. While the sequencer is busy, strobes are ignored, so only one transfer is ever outstanding. A timeout counter bounds every transfer to a limit set at a port.

Top module: `bm_xfer_seq`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `req_valid`, `done`, `err` and `slv_wr_ack` are 0 and `rd_data` is 0.
- R2: A `wr_strobe` sampled in idle starts a write. In the next cycle `busy` is 1 and `req_valid` is 1 for exactly one cycle, with `req_is_read`=0, `req_src_addr`=`WR_STAGE_ADDR` and `req_dst_addr`=`ext_addr`. The write staging register takes `wr_data`. The request addresses hold until the sequencer is idle again.
- R3: A `rd_strobe` sampled in idle starts a read with `req_is_read`=1, `req_src_addr`=`ext_addr` and `req_dst_addr`=`RD_STAGE_ADDR`. When both strobes are high in the same cycle, the write is started.
- R4: `slv_rd_data` depends combinationally on `slv_rd_addr`. It returns the write staging register when the address equals `WR_STAGE_ADDR`, the read staging register when it equals `RD_STAGE_ADDR`, and 0 otherwise. During a write, a slave read (`slv_rd_en`=1) of `WR_STAGE_ADDR` in the wait-slave state advances the sequencer to wait-completion.
- R5: During a read, a slave write (`slv_wr_en`=1) to `RD_STAGE_ADDR` in the wait-slave state loads `slv_wr_data` into the read staging register, which appears on `rd_data`. The same access makes `slv_wr_ack` pulse for one cycle in the next cycle. Slave writes at any other time, or to any other address, neither load the register nor acknowledge.
- R6: In wait-completion, `cmpl_ack` returns the sequencer to idle, and `done` pulses for one cycle in the following cycle. A `cmpl_ack` that arrives before the staging register has been accessed is ignored. `done` and `err` are never high together.
- R7: While `busy` is 1, both strobes are ignored. The request addresses, the transfer direction and the write staging register stay unchanged, and no second request follows the completion.
- R8: Count the request cycle as cycle 0. If the transfer has not finished by the end of cycle `tmo_limit`, the sequencer aborts to idle and `err` pulses for one cycle in the following cycle. A `cmpl_ack` in that last cycle of wait-completion takes priority and gives `done` instead.
- R9: After a transfer ends with done or with error, the next strobe in idle is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strobe | input | 1 | Custom logic requests a master write |
| rd_strobe | input | 1 | Custom logic requests a master read |
| ext_addr | input | AW | External address of the transfer |
| wr_data | input | DW | Word to write, captured into the write staging register on an accepted write strobe |
| tmo_limit | input | TW | Timeout limit in cycles |
| busy | output | 1 | A transfer is outstanding |
| done | output | 1 | One-cycle pulse: transfer completed |
| err | output | 1 | One-cycle pulse: transfer aborted by timeout |
| rd_data | output | DW | Read staging register contents |
| req_valid | output | 1 | One-cycle transfer request to the bus interface |
| req_is_read | output | 1 | Direction of the request: 1 for read, 0 for write |
| req_src_addr | output | AW | Source address of the request |
| req_dst_addr | output | AW | Destination address of the request |
| slv_rd_en | input | 1 | Interface slave read access |
| slv_rd_addr | input | AW | Slave read address |
| slv_rd_data | output | DW | Slave read data |
| slv_wr_en | input | 1 | Interface slave write access |
| slv_wr_addr | input | AW | Slave write address |
| slv_wr_data | input | DW | Slave write data |
| slv_wr_ack | output | 1 | Acknowledge of a slave write into the read staging register |
| cmpl_ack | input | 1 | Final completion acknowledge from the interface |

## Verification
The hardest cases to reach are the edges of the timeout window and of the protocol order. One is a completion acknowledge that lands in the very cycle the counter expires. Others are an acknowledge that comes too early, and a slave write aimed at the read staging register while a write transfer is waiting. The bench gets there by running directed transfers with a small `tmo_limit` and holding back or advancing each interface response by a counted number of cycles. It then checks `done`, `err`, `busy` and `rd_data` in the exact cycle that follows.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ       = 2'd1,
        ST_WAIT_SLV  = 2'd2,
        ST_WAIT_CMPL = 2'd3
    } bmx_state_t;
endpackage

// File: rtl/bmx_timer.sv
module bmx_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bmx_stage.sv
module bmx_stage #(
    parameter int            AW            = 32,
    parameter int            DW            = 32,
    parameter logic [AW-1:0] WR_STAGE_ADDR = '0,
    parameter logic [AW-1:0] RD_STAGE_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_wr,
    input  logic [DW-1:0] wr_data,
    input  logic          ld_rd,
    input  logic [DW-1:0] slv_wr_data,
    input  logic [AW-1:0] slv_rd_addr,
    output logic [DW-1:0] slv_rd_data,
    output logic [DW-1:0] rd_stage
);
    logic [DW-1:0] wr_stage_q;
    logic [DW-1:0] rd_stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stage_q <= '0;
            rd_stage_q <= '0;
        end else begin
            if (ld_wr) wr_stage_q <= wr_data;
            if (ld_rd) rd_stage_q <= slv_wr_data;
        end
    end

    always_comb begin
        if (slv_rd_addr == WR_STAGE_ADDR)      slv_rd_data = wr_stage_q;
        else if (slv_rd_addr == RD_STAGE_ADDR) slv_rd_data = rd_stage_q;
        else                                   slv_rd_data = '0;
    end

    assign rd_stage = rd_stage_q;
endmodule

// File: rtl/bmx_fsm.sv
module bmx_fsm
    import bmx_pkg::*;
#(
    parameter int            AW            = 32,
    parameter logic [AW-1:0] WR_STAGE_ADDR = '0,
    parameter logic [AW-1:0] RD_STAGE_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_strobe,
    input  logic          rd_strobe,
    input  logic [AW-1:0] ext_addr,
    input  logic          slv_rd_hit,
    input  logic          slv_wr_hit,
    input  logic          cmpl_ack,
    input  logic          expired,
    output logic          accept,
    output logic          ld_wr,
    output logic          ld_rd,
    output logic          busy,
    output logic          req_valid,
    output logic          req_is_read,
    output logic [AW-1:0] req_src_addr,
    output logic [AW-1:0] req_dst_addr,
    output logic          done,
    output logic          err,
    output logic          wr_ack
);
    bmx_state_t    state, state_nx;
    logic          is_read_q;
    logic [AW-1:0] addr_q;
    logic          done_q, err_q, wr_ack_q;
    logic          slv_step;
    logic          cmpl_take;
    logic          abort;

    assign accept    = (state == ST_IDLE) && (wr_strobe || rd_strobe);
    assign ld_wr     = accept && wr_strobe;
    assign slv_step  = is_read_q ? slv_wr_hit : slv_rd_hit;
    assign cmpl_take = (state == ST_WAIT_CMPL) && cmpl_ack;
    assign abort     = (state != ST_IDLE) && expired && !cmpl_take;
    assign ld_rd     = (state == ST_WAIT_SLV) && is_read_q && slv_wr_hit && !expired;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (wr_strobe || rd_strobe) state_nx = ST_REQ;
            ST_REQ:       state_nx = expired ? ST_IDLE : ST_WAIT_SLV;
            ST_WAIT_SLV: begin
                if (expired)       state_nx = ST_IDLE;
                else if (slv_step) state_nx = ST_WAIT_CMPL;
            end
            ST_WAIT_CMPL: if (cmpl_ack || expired) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // registered outputs and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
            addr_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            wr_ack_q  <= 1'b0;
        end else begin
            if (accept) begin
                is_read_q <= !wr_strobe;
                addr_q    <= ext_addr;
            end
            done_q   <= cmpl_take;
            err_q    <= abort;
            wr_ack_q <= ld_rd;
        end
    end

    assign busy         = (state != ST_IDLE);
    assign req_valid    = (state == ST_REQ);
    assign req_is_read  = is_read_q;
    assign req_src_addr = is_read_q ? addr_q : WR_STAGE_ADDR;
    assign req_dst_addr = is_read_q ? RD_STAGE_ADDR : addr_q;
    assign done         = done_q;
    assign err          = err_q;
    assign wr_ack       = wr_ack_q;

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_strobe || rd_strobe)) |=> ($stable(addr_q) && $stable(is_read_q)));

    p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_cmpl_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CMPL) |-> ($past(state) == ST_WAIT_SLV || $past(state) == ST_WAIT_CMPL));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && expired && !((state == ST_WAIT_CMPL) && cmpl_ack))
        |=> ((state == ST_IDLE) && err));

    p_ack_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (is_read_q && state == ST_WAIT_CMPL));
endmodule

// File: rtl/bm_xfer_seq.sv
module bm_xfer_seq #(
    parameter int            AW            = 32,
    parameter int            DW            = 32,
    parameter int            TW            = 16,
    parameter logic [AW-1:0] WR_STAGE_ADDR = AW'(32'h0000_1000),
    parameter logic [AW-1:0] RD_STAGE_ADDR = AW'(32'h0000_1004)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_strobe,
    input  logic          rd_strobe,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [TW-1:0] tmo_limit,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic          req_valid,
    output logic          req_is_read,
    output logic [AW-1:0] req_src_addr,
    output logic [AW-1:0] req_dst_addr,
    input  logic          slv_rd_en,
    input  logic [AW-1:0] slv_rd_addr,
    output logic [DW-1:0] slv_rd_data,
    input  logic          slv_wr_en,
    input  logic [AW-1:0] slv_wr_addr,
    input  logic [DW-1:0] slv_wr_data,
    output logic          slv_wr_ack,
    input  logic          cmpl_ack
);
    logic accept, ld_wr, ld_rd, expired;
    logic slv_rd_hit, slv_wr_hit;

    assign slv_rd_hit = slv_rd_en && (slv_rd_addr == WR_STAGE_ADDR);
    assign slv_wr_hit = slv_wr_en && (slv_wr_addr == RD_STAGE_ADDR);

    bmx_fsm #(
        .AW(AW), .WR_STAGE_ADDR(WR_STAGE_ADDR), .RD_STAGE_ADDR(RD_STAGE_ADDR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .ext_addr(ext_addr),
        .slv_rd_hit(slv_rd_hit), .slv_wr_hit(slv_wr_hit),
        .cmpl_ack(cmpl_ack), .expired(expired),
        .accept(accept), .ld_wr(ld_wr), .ld_rd(ld_rd),
        .busy(busy), .req_valid(req_valid), .req_is_read(req_is_read),
        .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
        .done(done), .err(err), .wr_ack(slv_wr_ack)
    );

    bmx_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(accept), .run(busy), .limit(tmo_limit), .expired(expired)
    );

    bmx_stage #(
        .AW(AW), .DW(DW), .WR_STAGE_ADDR(WR_STAGE_ADDR), .RD_STAGE_ADDR(RD_STAGE_ADDR)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .ld_wr(ld_wr), .wr_data(wr_data),
        .ld_rd(ld_rd), .slv_wr_data(slv_wr_data),
        .slv_rd_addr(slv_rd_addr), .slv_rd_data(slv_rd_data),
        .rd_stage(rd_data)
    );
endmodule

// File: tb/bm_xfer_seq_bench.sv
`timescale 1ns/1ps
module bm_xfer_seq_bench;
    localparam logic [31:0] WRA = 32'h0000_1000;
    localparam logic [31:0] RDA = 32'h0000_1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 0, rd_strobe = 0;
    logic [31:0] ext_addr = 0, wr_data = 0;
    logic [15:0] tmo_limit = 16'd20;
    logic        busy, done, err, req_valid, req_is_read, slv_wr_ack;
    logic [31:0] rd_data, req_src_addr, req_dst_addr, slv_rd_data;
    logic        slv_rd_en = 0, slv_wr_en = 0, cmpl_ack = 0;
    logic [31:0] slv_rd_addr = 0, slv_wr_addr = 0, slv_wr_data = 0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bm_xfer_seq u_bm_xfer_seq (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .ext_addr(ext_addr), .wr_data(wr_data), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .req_valid(req_valid), .req_is_read(req_is_read),
        .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
        .slv_rd_en(slv_rd_en), .slv_rd_addr(slv_rd_addr), .slv_rd_data(slv_rd_data),
        .slv_wr_en(slv_wr_en), .slv_wr_addr(slv_wr_addr), .slv_wr_data(slv_wr_data),
        .slv_wr_ack(slv_wr_ack), .cmpl_ack(cmpl_ack)
    );

    // {is_read, addr, data}
    localparam logic [64:0] VEC [4] = '{
        {1'b0, 32'h8000_0010, 32'hDEAD_BEEF},
        {1'b1, 32'h8000_0020, 32'h1234_5678},
        {1'b0, 32'h0000_0000, 32'h0000_0001},
        {1'b1, 32'hFFFF_FFFC, 32'hA5A5_5A5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic strobe(input bit is_rd, input logic [31:0] a, input logic [31:0] d);
        wr_strobe = !is_rd; rd_strobe = is_rd; ext_addr = a; wr_data = d;
        step();
        wr_strobe = 0; rd_strobe = 0;
    endtask

    task automatic run_xfer(input bit is_rd, input logic [31:0] a, input logic [31:0] d);
        strobe(is_rd, a, d);
        // request cycle
        chk("R2 busy", {31'd0, busy}, 32'd1);
        chk("R2 req_valid", {31'd0, req_valid}, 32'd1);
        chk(is_rd ? "R3 is_read" : "R2 is_read", {31'd0, req_is_read}, {31'd0, is_rd});
        chk(is_rd ? "R3 src" : "R2 src", req_src_addr, is_rd ? a : WRA);
        chk(is_rd ? "R3 dst" : "R2 dst", req_dst_addr, is_rd ? RDA : a);
        step();
        chk("R2 req single", {31'd0, req_valid}, 32'd0);
        if (is_rd) begin
            slv_wr_en = 1; slv_wr_addr = RDA; slv_wr_data = d;
        end else begin
            slv_rd_en = 1; slv_rd_addr = WRA;
            #0.5;
            chk("R4 slv_rd_data", slv_rd_data, d);
        end
        step();
        slv_wr_en = 0; slv_rd_en = 0;
        if (is_rd) begin
            chk("R5 wr_ack", {31'd0, slv_wr_ack}, 32'd1);
            chk("R5 rd_data", rd_data, d);
        end
        chk("R4 busy", {31'd0, busy}, 32'd1);
        chk("R2 dst held", req_dst_addr, is_rd ? RDA : a);
        cmpl_ack = 1;
        step();
        cmpl_ack = 0;
        chk("R6 done", {31'd0, done}, 32'd1);
        chk("R6 err", {31'd0, err}, 32'd0);
        chk("R6 idle", {31'd0, busy}, 32'd0);
        chk("R5 ack pulse", {31'd0, slv_wr_ack}, 32'd0);
        step();
        chk("R6 done pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        step(); step();
        chk("R1 busy in reset", {31'd0, busy}, 32'd0);
        chk("R1 req in reset", {31'd0, req_valid}, 32'd0);
        rst_n = 1;
        step();
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 wr_ack", {31'd0, slv_wr_ack}, 32'd0);
        chk("R1 rd_data", rd_data, 32'd0);

        foreach (VEC[i]) run_xfer(VEC[i][64], VEC[i][63:32], VEC[i][31:0]);

        // R4 decode of the slave read mux
        slv_rd_addr = RDA; #0.5;
        chk("R4 rd stage mux", slv_rd_data, 32'hA5A5_5A5A);
        slv_rd_addr = 32'h0000_2000; #0.5;
        chk("R4 other addr", slv_rd_data, 32'd0);
        step();

        // R5 stray slave write in idle
        slv_wr_en = 1; slv_wr_addr = RDA; slv_wr_data = 32'h0BAD_0BAD;
        step();
        slv_wr_en = 0;
        chk("R5 stray no ack", {31'd0, slv_wr_ack}, 32'd0);
        chk("R5 stray no load", rd_data, 32'hA5A5_5A5A);

        // R3 both strobes: write wins
        wr_strobe = 1; rd_strobe = 1; ext_addr = 32'h4000_0000; wr_data = 32'h0000_00AA;
        step();
        wr_strobe = 0; rd_strobe = 0;
        chk("R3 priority is_read", {31'd0, req_is_read}, 32'd0);
        chk("R3 priority dst", req_dst_addr, 32'h4000_0000);
        // R7 strobes while busy; R6 early cmpl ack ignored
        rd_strobe = 1; ext_addr = 32'h5000_0000; cmpl_ack = 1;
        step();
        rd_strobe = 0;
        wr_strobe = 1; wr_data = 32'h0000_00BB; ext_addr = 32'h6000_0000;
        step();
        wr_strobe = 0; cmpl_ack = 0;
        chk("R6 early ack ignored", {31'd0, busy}, 32'd1);
        chk("R7 dst unchanged", req_dst_addr, 32'h4000_0000);
        chk("R7 dir unchanged", {31'd0, req_is_read}, 32'd0);
        // R5 slave write to read stage during a write transfer is ignored
        slv_wr_en = 1; slv_wr_addr = RDA; slv_wr_data = 32'h7777_7777;
        slv_rd_en = 1; slv_rd_addr = WRA; #0.5;
        chk("R7 stage unchanged", slv_rd_data, 32'h0000_00AA);
        step();
        slv_wr_en = 0; slv_rd_en = 0;
        chk("R5 no ack on write xfer", {31'd0, slv_wr_ack}, 32'd0);
        chk("R5 no load on write xfer", rd_data, 32'hA5A5_5A5A);
        cmpl_ack = 1;
        step();
        cmpl_ack = 0;
        chk("R6 done after order", {31'd0, done}, 32'd1);
        step();
        chk("R7 no second request", {31'd0, req_valid}, 32'd0);
        step();
        chk("R7 stays idle", {31'd0, busy}, 32'd0);

        // R8 timeout with no slave access, limit 3
        tmo_limit = 16'd3;
        strobe(1'b0, 32'h9000_0000, 32'h0000_0055);
        step(); step(); step();
        chk("R8 busy at last cycle", {31'd0, busy}, 32'd1);
        step();
        chk("R8 err", {31'd0, err}, 32'd1);
        chk("R8 idle", {31'd0, busy}, 32'd0);
        chk("R8 no done", {31'd0, done}, 32'd0);
        step();
        chk("R8 err pulse", {31'd0, err}, 32'd0);

        // R8 completion in the expiring cycle wins
        strobe(1'b0, 32'h9000_0004, 32'h0000_0066);
        step();
        slv_rd_en = 1; slv_rd_addr = WRA;
        step();
        slv_rd_en = 0;
        step();
        cmpl_ack = 1;
        step();
        cmpl_ack = 0;
        chk("R8 ack wins done", {31'd0, done}, 32'd1);
        chk("R8 ack wins no err", {31'd0, err}, 32'd0);
        step();

        // R9 normal transfer after error and done
        tmo_limit = 16'd20;
        run_xfer(1'b1, 32'h3000_0000, 32'hC0FF_EE00);
        chk("R9 rd_data after recovery", rd_data, 32'hC0FF_EE00);

        finish_run();
    end
endmodule